// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution core of a small register-based processor. One control word is applied each cycle. It names a source for each of two operand buses, an arithmetic or logic function, and a destination register. The block has seven general registers. A source code of zero reads the external input port instead of a register. The function result appears at once on the output port. At the next rising clock edge the result is written into the chosen register, unless the destination code is zero.

A sequencer outside this block supplies the control word. A register's value is sent to the output by passing it through the function unit with no destination. A register is cleared by an exclusive-OR with itself, written back to the same register.

Top module: `cwd_datapath`

## Requirements
- R1: A synchronous active-low reset clears all seven registers to zero.
- R2: The control word is split into four fields:
  - bits [13:11] select bus A;
  - bits [10:8] select bus B;
  - bits [7:5] select the destination;
  - bits [4:0] select the function.
- R3: For either operand bus, select code 000 reads `ext_in`, and codes 001 to 111 read registers 1 to 7.
- R4: Destination code 000 leaves every register unchanged. Codes 001 to 111 load the value of `out_bus` into registers 1 to 7 at the rising clock edge.
- R5: Arithmetic function codes wrap modulo 2^8:
  - 00000 passes A;
  - 00001 gives A+1;
  - 00010 gives A+B;
  - 00101 gives A-B;
  - 00110 gives A-1.
- R6: Logic function codes:
  - 01000 gives A AND B;
  - 01010 gives A OR B;
  - 01100 gives A XOR B;
  - 01110 gives NOT A.
- R7: Code 10000 shifts A right by one bit and code 11000 shifts A left by one bit. Both shifts are logical: the bit that is vacated becomes 0.
- R8: Any other function code drives `out_bus` to zero. The destination field still applies, so the selected register is loaded with zero.
- R9: `out_bus` shows the function result for the current control word with no register delay. When a register is read and written in the same cycle, the read returns the old value, and the new value can be seen from the next cycle on.
- R10: A control word that selects the same register for A, B and the destination, with the XOR function, clears that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 14 | Control word: A select, B select, destination select, function |
| ext_in | input | 8 | External operand, read through select code 000 |
| out_bus | output | 8 | Function result, visible continuously |

## Verification
The bench builds the block with its default parameters: 8-bit data and 3-bit selects. With these values all seven registers, the external-input code and the wrap points at 0x00 and 0xFF can be reached in a few dozen cycles. Each register is observed through its normal path, by passing it to the output with no destination. This shows both that writes took effect and that writes with destination 000 were suppressed. One control word uses different registers for A and B with subtraction, so a swap of the two select fields changes the result.

// File: rtl/cwd_pkg.sv
// Package: shared function codes for the control-word datapath.
// Assumes a 5-bit function field; the codes are sparse and fixed.
package cwd_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        FN_PASS = 5'b00000,
        FN_INC  = 5'b00001,
        FN_ADD  = 5'b00010,
        FN_SUB  = 5'b00101,
        FN_DEC  = 5'b00110,
        FN_AND  = 5'b01000,
        FN_OR   = 5'b01010,
        FN_XOR  = 5'b01100,
        FN_NOT  = 5'b01110,
        FN_SHR  = 5'b10000,
        FN_SHL  = 5'b11000
    } fn_code_e;

endpackage

// File: rtl/cwd_alu.sv
// Module: combinational function unit.
// Decodes the sparse function code and computes the result from buses A and B.
// Assumes arithmetic wraps at DATA_W bits; unknown codes produce zero.
module cwd_alu
    import cwd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   fn_code,
    output logic [DATA_W-1:0] result
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Select the function result for the current code
    always_comb begin
        case (fn_code)
            FN_PASS: result = opnd_a;
            FN_INC:  result = opnd_a + ONE;
            FN_ADD:  result = opnd_a + opnd_b;
            FN_SUB:  result = opnd_a - opnd_b;
            FN_DEC:  result = opnd_a - ONE;
            FN_AND:  result = opnd_a & opnd_b;
            FN_OR:   result = opnd_a | opnd_b;
            FN_XOR:  result = opnd_a ^ opnd_b;
            FN_NOT:  result = ~opnd_a;
            FN_SHR:  result = {1'b0, opnd_a[DATA_W-1:1]};
            FN_SHL:  result = {opnd_a[DATA_W-2:0], 1'b0};
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/cwd_srcmux.sv
// Module: operand source selector.
// Code 0 picks the external input; code n picks register n of the flat bank.
// Assumes NREG = 2**SEL_W - 1, so every select code is legal.
module cwd_srcmux #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int NREG   = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0]       src_sel,
    input  logic [DATA_W-1:0]      ext_val,
    input  logic [NREG*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]      bus_val
);

    logic [DATA_W-1:0] choice [0:NREG];

    assign choice[0] = ext_val;

    for (genvar i = 1; i <= NREG; i++) begin : g_choice
        assign choice[i] = bank_flat[(i-1)*DATA_W +: DATA_W];
    end

    // Route the selected candidate onto the bus
    always_comb begin
        bus_val = choice[src_sel];
    end

endmodule

// File: rtl/cwd_regbank.sv
// Module: general register bank with destination decode.
// Register n loads wr_data when wr_sel equals n; code 0 loads nothing.
// Assumes a synchronous active-low reset that clears every register.
module cwd_regbank #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    parameter int NREG   = (1 << SEL_W) - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [NREG*DATA_W-1:0] bank_flat
);

    for (genvar i = 1; i <= NREG; i++) begin : g_reg
        logic [DATA_W-1:0] q;

        // Clear on reset, else load when this register is the destination
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_sel == SEL_W'(i)) begin
                q <= wr_data;
            end
        end

        assign bank_flat[(i-1)*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/cwd_datapath.sv
// Module: control-word register datapath (top).
// Splits the control word into A select, B select, destination and function.
// Drives both operand buses, computes the result onto out_bus and writes it back.
// Assumes one control word per cycle, supplied by an outside sequencer.
module cwd_datapath
    import cwd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3*SEL_W+OP_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0]         ext_in,
    output logic [DATA_W-1:0]         out_bus
);

    localparam int NREG = (1 << SEL_W) - 1;
    localparam int CW_W = 3 * SEL_W + OP_W;

    logic [SEL_W-1:0]       sel_a;
    logic [SEL_W-1:0]       sel_b;
    logic [SEL_W-1:0]       sel_d;
    logic [OP_W-1:0]        fn_sel;
    logic [NREG*DATA_W-1:0] regs_flat;
    logic [SEL_W-1:0]       src_sel [2];
    logic [DATA_W-1:0]      src_bus [2];

    // Field split of the control word
    assign sel_a  = ctrl_word[CW_W-1 -: SEL_W];
    assign sel_b  = ctrl_word[CW_W-1-SEL_W -: SEL_W];
    assign sel_d  = ctrl_word[OP_W+SEL_W-1 -: SEL_W];
    assign fn_sel = ctrl_word[OP_W-1:0];

    assign src_sel[0] = sel_a;
    assign src_sel[1] = sel_b;

    for (genvar s = 0; s < 2; s++) begin : g_src
        cwd_srcmux #(
            .DATA_W (DATA_W),
            .SEL_W  (SEL_W),
            .NREG   (NREG)
        ) u_mux (
            .src_sel   (src_sel[s]),
            .ext_val   (ext_in),
            .bank_flat (regs_flat),
            .bus_val   (src_bus[s])
        );
    end

    cwd_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .opnd_a  (src_bus[0]),
        .opnd_b  (src_bus[1]),
        .fn_code (fn_sel),
        .result  (out_bus)
    );

    cwd_regbank #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .NREG   (NREG)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (sel_d),
        .wr_data   (out_bus),
        .bank_flat (regs_flat)
    );

endmodule

// File: rtl/cwd_datapath_chk.sv
// Module: assertion checker for cwd_datapath, attached by bind.
// Observes the ports and the register bank; drives nothing back.
module cwd_datapath_chk
    import cwd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [3*SEL_W+OP_W-1:0]              ctrl_word,
    input logic [DATA_W-1:0]                    ext_in,
    input logic [DATA_W-1:0]                    out_bus,
    input logic [((1<<SEL_W)-1)*DATA_W-1:0]     regs_flat
);

    localparam int NREG = (1 << SEL_W) - 1;
    localparam int CW_W = 3 * SEL_W + OP_W;

    logic [SEL_W-1:0]  c_sa;
    logic [SEL_W-1:0]  c_sb;
    logic [SEL_W-1:0]  c_sd;
    logic [OP_W-1:0]   c_fn;
    logic [SEL_W-1:0]  sd_q;
    logic [DATA_W-1:0] reg_view [0:NREG];

    assign c_sa = ctrl_word[CW_W-1 -: SEL_W];
    assign c_sb = ctrl_word[CW_W-1-SEL_W -: SEL_W];
    assign c_sd = ctrl_word[OP_W+SEL_W-1 -: SEL_W];
    assign c_fn = ctrl_word[OP_W-1:0];

    assign reg_view[0] = '0;
    for (genvar i = 1; i <= NREG; i++) begin : g_view
        assign reg_view[i] = regs_flat[(i-1)*DATA_W +: DATA_W];
    end

    // Remember last cycle's destination to look up the written register
    always_ff @(posedge clk) begin
        if (!rst_n) sd_q <= '0;
        else        sd_q <= c_sd;
    end

    // R4
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sd != '0) |=> (reg_view[sd_q] == $past(out_bus)));

    // R4
    no_dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sd == '0) |=> $stable(regs_flat));

    // R3
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sa == '0 && c_fn == FN_PASS) |-> (out_bus == ext_in));

    // R5
    ext_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sa == '0 && c_sb == '0 && c_fn == FN_ADD) |-> (out_bus == DATA_W'(ext_in + ext_in)));

    // R8
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_fn inside {FN_PASS, FN_INC, FN_ADD, FN_SUB, FN_DEC, FN_AND,
                       FN_OR, FN_XOR, FN_NOT, FN_SHR, FN_SHL}) |-> (out_bus == '0));

endmodule

bind cwd_datapath cwd_datapath_chk #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .ext_in    (ext_in),
    .out_bus   (out_bus),
    .regs_flat (regs_flat)
);

// File: tb/cwd_datapath_tb_top.sv
// Bench: scoreboard for cwd_datapath.
// A driver task applies a control word and queues the literal expected out_bus value.
// A monitor pops and compares one time unit after each falling edge.
module cwd_datapath_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] F_PASS = 5'b00000;
    localparam logic [4:0] F_INC  = 5'b00001;
    localparam logic [4:0] F_ADD  = 5'b00010;
    localparam logic [4:0] F_SUB  = 5'b00101;
    localparam logic [4:0] F_DEC  = 5'b00110;
    localparam logic [4:0] F_AND  = 5'b01000;
    localparam logic [4:0] F_OR   = 5'b01010;
    localparam logic [4:0] F_XOR  = 5'b01100;
    localparam logic [4:0] F_NOT  = 5'b01110;
    localparam logic [4:0] F_SHR  = 5'b10000;
    localparam logic [4:0] F_SHL  = 5'b11000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ctrl_word = '0;
    logic [7:0]  ext_in = '0;
    logic [7:0]  out_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    cwd_datapath dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .ext_in    (ext_in),
        .out_bus   (out_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply a raw control word, queue the expected result, let the edge pass
    task automatic run_raw(input logic [13:0] cw, input logic [7:0] din,
                           input logic [7:0] expv, input string tag);
        @(negedge clk);
        ctrl_word = cw;
        ext_in    = din;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    task automatic run_cw(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                          input logic [4:0] fn, input logic [7:0] din,
                          input logic [7:0] expv, input string tag);
        run_raw({sa, sb, sd, fn}, din, expv, tag);
    endtask

    // Read a register through pass-A with no destination
    task automatic expect_reg(input logic [2:0] r, input logic [7:0] expv, input string tag);
        run_cw(r, 3'd0, 3'd0, F_PASS, 8'h00, expv, tag);
    endtask

    // Monitor: compare queued expectations away from the clock edges
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (out_bus !== e) begin
                    errors++;
                    $display("FAIL %s: out_bus=%h expected %h", t, out_bus, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers zero after reset
        for (int r = 1; r <= 7; r++) expect_reg(3'(r), 8'h00, "R1 reset value");

        // R3: load from external input; R9: out_bus shows the result at once
        run_cw(3'd0, 3'd0, 3'd1, F_PASS, 8'h3C, 8'h3C, "R3 ext to R1");
        run_cw(3'd0, 3'd0, 3'd2, F_PASS, 8'hC5, 8'hC5, "R3 ext to R2");
        run_cw(3'd0, 3'd0, 3'd3, F_PASS, 8'hFF, 8'hFF, "R3 ext to R3");
        expect_reg(3'd1, 8'h3C, "R4 R1 written");
        expect_reg(3'd2, 8'hC5, "R4 R2 written");

        // R5: arithmetic, including wrap at both ends
        run_cw(3'd1, 3'd2, 3'd4, F_ADD, 8'h00, 8'h01, "R5 add wrap");
        expect_reg(3'd4, 8'h01, "R5 add stored");
        run_cw(3'd1, 3'd2, 3'd5, F_SUB, 8'h00, 8'h77, "R5 sub borrow");
        expect_reg(3'd5, 8'h77, "R5 sub stored");
        run_cw(3'd3, 3'd0, 3'd6, F_INC, 8'h00, 8'h00, "R5 inc wrap");
        run_cw(3'd6, 3'd0, 3'd7, F_DEC, 8'h00, 8'hFF, "R5 dec wrap");
        expect_reg(3'd7, 8'hFF, "R5 dec stored");

        // R6, R7: logic and shifts with no destination
        run_cw(3'd1, 3'd2, 3'd0, F_AND, 8'h00, 8'h04, "R6 and");
        run_cw(3'd1, 3'd2, 3'd0, F_OR,  8'h00, 8'hFD, "R6 or");
        run_cw(3'd1, 3'd2, 3'd0, F_XOR, 8'h00, 8'hF9, "R6 xor");
        run_cw(3'd1, 3'd0, 3'd0, F_NOT, 8'h00, 8'hC3, "R6 not");
        run_cw(3'd2, 3'd0, 3'd0, F_SHR, 8'h00, 8'h62, "R7 shr zero fill");
        run_cw(3'd2, 3'd0, 3'd0, F_SHL, 8'h00, 8'h8A, "R7 shl drop msb");
        expect_reg(3'd1, 8'h3C, "R4 R1 held with dest 000");
        expect_reg(3'd2, 8'hC5, "R4 R2 held with dest 000");

        // R3: bus B from external input
        run_cw(3'd1, 3'd0, 3'd0, F_ADD, 8'h04, 8'h40, "R3 B from ext");

        // R8: undefined codes give zero and still write
        run_cw(3'd1, 3'd2, 3'd4, 5'b00011, 8'h00, 8'h00, "R8 undefined to R4");
        expect_reg(3'd4, 8'h00, "R8 zero stored");
        run_cw(3'd2, 3'd2, 3'd0, 5'b11111, 8'h00, 8'h00, "R8 undefined no dest");

        // R9: read and write of the same register in one cycle
        run_cw(3'd1, 3'd0, 3'd1, F_INC, 8'h00, 8'h3D, "R9 inc in place");
        run_cw(3'd1, 3'd1, 3'd1, F_ADD, 8'h00, 8'h7A, "R9 old value read");
        expect_reg(3'd1, 8'h7A, "R9 new value next cycle");

        // R10: clear by XOR with itself
        run_cw(3'd5, 3'd5, 3'd5, F_XOR, 8'h00, 8'h00, "R10 clear result");
        expect_reg(3'd5, 8'h00, "R10 cleared");

        // R2: field positions; A=R2 (C5), B=R1 (7A), subtract
        run_raw(14'b010_001_000_00101, 8'h00, 8'h4B, "R2 field order");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule